// File: doc/BRIEF.md
# Byte-Granular Write Splitter

This block takes a write of any byte length, from zero up to 65535 bytes, starting at any byte address. It turns that write into a series of aligned 16-bit halfword writes for a memory that can only be written a whole halfword at a time. A transfer is opened with a start pulse that carries the byte address and the length. The payload then arrives as a byte stream with valid/ready handshaking. Each halfword write is held on the write port until the memory acknowledges it with a done pulse.

When a byte does not pair up with a partner inside the transfer, the block reads the enclosing halfword through a one-cycle-latency read port. It keeps the neighbouring byte from that read and writes back the merged halfword. There are two such cases: a leading byte at an odd address, and a single byte left over at the end. Bytes that do pair up are packed little-endian and written with no read. A one-cycle done pulse marks the end of the whole transfer.

Top module: `bytewr_split`

## Requirements
- R1: A start pulse is taken only while `busy` is low; a start pulse while a transfer is in progress has no effect, so it causes no write and changes no memory byte.
- R2: If the start address is odd, the first byte is written alone, before any pair. The halfword holds the new byte in bits 15:8 and the byte read back from address-1 in bits 7:0.
- R3: A lone byte at an even address is written with the new byte in bits 7:0 and the byte read back from address+1 in bits 15:8.
- R4: Every halfword write address and every merge read address has bit 0 equal to 0.
- R5: Two bytes that pair up are written as one halfword with no read. The earlier byte goes in bits 7:0 and the later byte in bits 15:8, and the address advances by 2 per pair.
- R6: A single byte left over after the pairs is written with the rule of R3.
- R7: A length of zero causes no write and no read, and `xfer_done` pulses in the cycle after the start pulse.
- R8: At most one halfword write is outstanding. `wr_req`, `wr_addr` and `wr_data` stay stable until `wr_done`, and `in_ready` is low while `wr_req` is high.
- R9: `xfer_done` is a one-cycle pulse given once per transfer, after the final write is acknowledged. Memory bytes outside the transfer's range are left unchanged.
- R10: Each merge read is a one-cycle `rd_en` pulse. Its data is taken one cycle after the pulse, and the number of reads equals the number of single-byte writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a transfer when idle |
| start_addr | input | AW | Byte address of the first byte |
| start_len | input | LW | Number of bytes in the transfer |
| busy | output | 1 | A transfer is in progress |
| xfer_done | output | 1 | One-cycle pulse when the transfer ends |
| in_valid | input | 1 | Stream byte is valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block takes the stream byte this cycle |
| wr_req | output | 1 | Halfword write request, held until acknowledged |
| wr_addr | output | AW | Byte address of the halfword, bit 0 clear |
| wr_data | output | 16 | Halfword to write, bits 7:0 at the even byte |
| wr_done | input | 1 | Memory acknowledges the pending write |
| rd_en | output | 1 | Merge read request |
| rd_addr | output | AW | Byte address of the halfword to read, bit 0 clear |
| rd_data | input | 16 | Read halfword, valid one cycle after `rd_en` |

## Verification
Two events can land in the same cycle: the acknowledgement of a transfer's final halfword write and a fresh start request. The bench watches `wr_done` after the last byte has been fed. It raises `start` with a new address and length for exactly the clock edge at which that final acknowledgement is sampled. It then checks three things: the second request causes no further write, the bytes it names are left unchanged, and `busy` falls and stays low. It also checks that a single `xfer_done` pulse is seen.

// File: rtl/bytewr_split_pkg.sv
package bytewr_split_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TAKE   = 3'd1,
    ST_TAKE2  = 3'd2,
    ST_RDISS  = 3'd3,
    ST_RDWAIT = 3'd4,
    ST_WRITE  = 3'd5
  } split_state_t;

  typedef struct packed {
    logic [7:0] value;
    logic       upper;
  } lone_byte_t;

endpackage

// File: rtl/bws_merge.sv
module bws_merge (
  input  logic [7:0]  new_byte,
  input  logic        upper,
  input  logic [15:0] old_hw,
  output logic [15:0] merged
);

  always_comb begin
    if (upper) begin
      merged = {new_byte, old_hw[7:0]};
    end else begin
      merged = {old_hw[15:8], new_byte};
    end
  end

endmodule

// File: rtl/bws_cursor.sv
module bws_cursor #(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [LW-1:0] load_len,
  input  logic          step,
  input  logic [1:0]    step_size,
  output logic [AW-1:0] cur_addr,
  output logic [LW-1:0] remaining,
  output logic          odd_pos,
  output logic          one_left,
  output logic          last_step
);

  localparam logic [LW-1:0] ONE = LW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr  <= '0;
      remaining <= '0;
    end else if (load) begin
      cur_addr  <= load_addr;
      remaining <= load_len;
    end else if (step) begin
      cur_addr  <= cur_addr + AW'(step_size);
      remaining <= remaining - LW'(step_size);
    end
  end

  assign odd_pos   = cur_addr[0];
  assign one_left  = (remaining == ONE);
  assign last_step = (remaining == LW'(step_size));

endmodule

// File: rtl/bytewr_split.sv
module bytewr_split
  import bytewr_split_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  output logic          busy,
  output logic          xfer_done,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data,
  input  logic          wr_done,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [15:0]   rd_data
);

  split_state_t state;
  lone_byte_t   lone;
  logic [7:0]   pair_lo;
  logic [1:0]   pend_size;

  logic          cur_load;
  logic          cur_step;
  logic [AW-1:0] cur_addr;
  logic [LW-1:0] remaining;
  logic          odd_pos;
  logic          one_left;
  logic          last_step;
  logic [15:0]   merged;
  logic [AW-1:0] aligned;
  logic          take_ok;

  assign aligned  = {cur_addr[AW-1:1], 1'b0};
  assign take_ok  = in_valid && in_ready;
  assign cur_load = (state == ST_IDLE) && start;
  assign cur_step = (state == ST_WRITE) && wr_done;
  assign in_ready = (state == ST_TAKE) || (state == ST_TAKE2);
  assign busy     = (state != ST_IDLE);

  bws_cursor #(.AW(AW), .LW(LW)) i_cursor (
    .clk       (clk),
    .rst       (rst),
    .load      (cur_load),
    .load_addr (start_addr),
    .load_len  (start_len),
    .step      (cur_step),
    .step_size (pend_size),
    .cur_addr  (cur_addr),
    .remaining (remaining),
    .odd_pos   (odd_pos),
    .one_left  (one_left),
    .last_step (last_step)
  );

  bws_merge i_merge (
    .new_byte (lone.value),
    .upper    (lone.upper),
    .old_hw   (rd_data),
    .merged   (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      lone      <= '0;
      pair_lo   <= '0;
      pend_size <= 2'd1;
      xfer_done <= 1'b0;
      wr_req    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
    end else begin
      xfer_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (start_len == '0) begin
              xfer_done <= 1'b1;
            end else begin
              state <= ST_TAKE;
            end
          end
        end
        ST_TAKE: begin
          if (take_ok) begin
            if (odd_pos || one_left) begin
              lone.value <= in_data;
              lone.upper <= odd_pos;
              pend_size  <= 2'd1;
              rd_en      <= 1'b1;
              rd_addr    <= aligned;
              state      <= ST_RDISS;
            end else begin
              pair_lo <= in_data;
              state   <= ST_TAKE2;
            end
          end
        end
        ST_TAKE2: begin
          if (take_ok) begin
            wr_data   <= {in_data, pair_lo};
            wr_addr   <= aligned;
            wr_req    <= 1'b1;
            pend_size <= 2'd2;
            state     <= ST_WRITE;
          end
        end
        ST_RDISS: begin
          rd_en <= 1'b0;
          state <= ST_RDWAIT;
        end
        ST_RDWAIT: begin
          wr_data <= merged;
          wr_addr <= rd_addr;
          wr_req  <= 1'b1;
          state   <= ST_WRITE;
        end
        ST_WRITE: begin
          if (wr_done) begin
            wr_req <= 1'b0;
            if (last_step) begin
              xfer_done <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              state <= ST_TAKE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Write address is halfword aligned
  assert_wr_even_R4: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> (wr_addr[0] == 1'b0));

  assert_rd_even_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr[0] == 1'b0));

  // A pending write holds until acknowledged
  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_no_take_during_write_R8: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> !in_ready);

  // Merge read is a single-cycle pulse
  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  // Done pulse is single-cycle and leaves the block idle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (!wr_req && !busy) ##1 !xfer_done);

  // Start while busy leaves the cursor untouched
  assert_start_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !(state == ST_WRITE && wr_done)) |=> $stable(remaining));

endmodule

// File: tb/test_bytewr_split.sv
module test_bytewr_split;

  localparam int AW = 6;
  localparam int LW = 16;
  localparam int MB = 1 << AW;
  localparam int NV = 8;

  // {start address, length, seed}
  localparam logic [7:0] VEC [NV][3] = '{
    '{8'd3,  8'd8,  8'h11},
    '{8'd4,  8'd6,  8'h22},
    '{8'd9,  8'd1,  8'h33},
    '{8'd12, 8'd1,  8'h44},
    '{8'd20, 8'd5,  8'h55},
    '{8'd31, 8'd2,  8'h66},
    '{8'd40, 8'd0,  8'h77},
    '{8'd0,  8'd17, 8'h88}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] start_len = '0;
  logic          busy, xfer_done, in_ready, wr_req, rd_en;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [15:0]   wr_data;
  logic          wr_done;
  logic [15:0]   rd_data;

  logic [7:0] mem [MB];
  logic [7:0] shadow [MB];
  logic       init_go = 1'b0;
  logic [7:0] init_seed = '0;
  int         wcnt, rcnt, dcnt, badaddr, rdy_bad, lat;
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;

  bytewr_split #(.AW(AW), .LW(LW)) i_bytewr_split (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .start_len(start_len), .busy(busy), .xfer_done(xfer_done),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_done(wr_done),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Memory model: one-cycle read, write acknowledged after a short latency
  always @(posedge clk) begin
    if (init_go) begin
      for (int k = 0; k < MB; k++) mem[k] <= init_seed ^ 8'(k * 3);
      wcnt <= 0; rcnt <= 0; dcnt <= 0; badaddr <= 0; rdy_bad <= 0;
      lat <= 0; wr_done <= 1'b0; rd_data <= '0;
    end else begin
      if (rd_en) begin
        rd_data <= {mem[{rd_addr[AW-1:1], 1'b1}], mem[{rd_addr[AW-1:1], 1'b0}]};
        rcnt <= rcnt + 1;
        if (rd_addr[0]) badaddr <= badaddr + 1;
      end
      if (xfer_done) dcnt <= dcnt + 1;
      if (wr_req && in_ready) rdy_bad <= rdy_bad + 1;
      if (wr_done) begin
        wr_done <= 1'b0;
      end else if (wr_req) begin
        if (lat == 2) begin
          mem[{wr_addr[AW-1:1], 1'b0}] <= wr_data[7:0];
          mem[{wr_addr[AW-1:1], 1'b1}] <= wr_data[15:8];
          if (wr_addr[0]) badaddr <= badaddr + 1;
          wcnt <= wcnt + 1;
          wr_done <= 1'b1;
          lat <= 0;
        end else begin
          lat <= lat + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_mem(input logic [7:0] seed);
    @(negedge clk);
    init_seed = seed; init_go = 1'b1;
    for (int k = 0; k < MB; k++) shadow[k] = seed ^ 8'(k * 3);
    @(negedge clk);
    init_go = 1'b0;
  endtask

  task automatic compare_mem(input string req);
    int diffs = 0;
    int first = -1;
    for (int k = 0; k < MB; k++) begin
      if (mem[k] !== shadow[k]) begin
        diffs++;
        if (first < 0) first = k;
      end
    end
    if (first < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, int'(mem[first]), int'(shadow[first]));
  endtask

  // Runs a transfer; poke raises a second start on the final acknowledgement
  task automatic run_xfer(input int addr, input int len, input logic [7:0] seed,
                          input bit poke);
    int single_cnt, rest, nexp;
    load_mem(seed);
    start_addr = AW'(addr); start_len = LW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (len == 0) check(xfer_done == 1'b1, "R7 done timing", int'(xfer_done), 1);
    for (int i = 0; i < len; i++) begin
      if (i % 3 == 2) begin in_valid = 1'b0; @(negedge clk); end
      in_valid = 1'b1;
      in_data = 8'(seed + 8'(i * 13) + 8'd1);
      shadow[(addr + i) % MB] = in_data;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    if (poke && len > 0) begin
      while (!wr_done) @(negedge clk);
      start_addr = AW'(50); start_len = LW'(2); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 60 && busy; t++) @(negedge clk);
    repeat (6) @(negedge clk);
    single_cnt = 0; rest = len;
    if (len > 0 && addr % 2 == 1) begin single_cnt = 1; rest = len - 1; end
    single_cnt += rest % 2;
    nexp = single_cnt + rest / 2;
    compare_mem("R2/R3/R5/R6/R9 contents");
    check(wcnt == nexp, "R5 write count", wcnt, nexp);
    check(dcnt == 1, "R9 done pulses", dcnt, 1);
    check(rcnt == single_cnt, "R10 read count", rcnt, single_cnt);
    check(badaddr == 0, "R4 aligned", badaddr, 0);
    check(rdy_bad == 0, "R8 ready during write", rdy_bad, 0);
    if (poke) check(busy == 1'b0, "R1 busy after ignored start", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    load_mem(8'h00);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !wr_req && !rd_en && !in_ready && !xfer_done,
          "R9 reset state", int'({busy, wr_req, rd_en, in_ready, xfer_done}), 0);
    for (int v = 0; v < NV; v++)
      run_xfer(int'(VEC[v][0]), int'(VEC[v][1]), VEC[v][2], 1'b0);
    // R2 single odd byte merges with lower neighbour
    run_xfer(1, 1, 8'h5A, 1'b0);
    // R6 trailing byte after pairs
    run_xfer(60, 3, 8'hC3, 1'b0);
    // R1 start landing on the final acknowledgement is ignored
    run_xfer(10, 4, 8'h99, 1'b1);
    // R7 zero length at odd address
    run_xfer(7, 0, 8'h12, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule